// File: doc/BRIEF.md
# DMA Channel Register Bank with Start Control

This block holds the software-visible registers of a seven-channel DMA controller. Each channel has three 32-bit registers: a memory address, a block control word and a channel control word. A shared 32-bit primary control register holds one enable bit per channel. The bus reaches all of them through a simple 32-bit register port. Writes take effect on the clock edge where `reg_wr` is high. Reads are registered, so `reg_rdata` is valid in the cycle after `reg_rd`.

A transfer can start only from a write to a channel's control register. Two conditions must also hold: the written value has the start bit set, and that channel's enable bit in the primary control register is set. When the start is accepted, the channel does three things:
- It raises `xfer_start` for exactly one cycle.
- It raises `xfer_busy`.
- It captures the address, block control and control values onto its request outputs.

Those outputs stay frozen until the data mover returns a `xfer_done` pulse. That pulse clears the start bit in the stored control word, drops `xfer_busy` and produces a one-cycle `xfer_finish`. The channel at index 5 stores writes but never starts.

The start/done pair is a plain handshake. A start is a request that the mover must accept. The block applies no back-pressure of its own: a request stays outstanding, with stable payload, until the done pulse arrives.

Top module: `dma_reg_bank`

## Requirements
- R1: After reset, every register reads 0, `reg_rdata` is 0, and no channel is started, busy or finishing.
- R2: Channel n's address register sits at byte offset 0x80+0x10·n and its block control register at 0x84+0x10·n. Writes to these two registers store the value, read back unchanged, and never start a transfer.
- R3: Channel n's control register sits at 0x88+0x10·n. A write there starts the channel when all of the following hold:
  - the written value has bit 24 set;
  - bit 3+4·n of the primary register is set;
  - the channel is idle.
  The cycle after the write edge, `xfer_start[n]` is high for exactly one cycle. The request outputs then carry the channel's stored address, block control and the newly written control value.
- R4: A control write with bit 24 set while the channel's enable bit is clear stores the value and does not start. Setting the enable bit afterwards does not start the channel either.
- R5: A control write with bit 24 clear stores the value and does not start.
- R6: While `xfer_busy[n]` is high, the request outputs of channel n stay stable, even if the channel's registers are rewritten.
- R7: A `xfer_done[n]` pulse while busy has three effects at the next edge: `xfer_busy[n]` drops, bit 24 of the stored control word clears, and `xfer_finish[n]` is high for one cycle.
- R8: Channel 5 stores its register writes but never starts, even with bit 24 and its enable bit set.
- R9: A control write to a busy channel stores the value but issues no second start.
- R10: The primary control register sits at 0xF0 and reads back as written. A read of any other unmapped offset returns 0.
- R11: Read data appears on `reg_rdata` in the cycle after `reg_rd` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| xfer_done | input | 7 | Per-channel completion pulse from the data mover |
| xfer_start | output | 7 | Per-channel one-cycle start request |
| xfer_busy | output | 7 | Per-channel transfer outstanding |
| xfer_finish | output | 7 | Per-channel one-cycle completion pulse |
| xfer_addr | output | 224 | Captured address; channel n in bits 32n+31:32n |
| xfer_blk | output | 224 | Captured block control; channel n in bits 32n+31:32n |
| xfer_ctl | output | 224 | Captured control word; channel n in bits 32n+31:32n |

## Verification
The bench targets four corner cases:
- **Enable set after a pending start bit (R4).** A design that re-evaluated the start condition on a primary-register write would launch a transfer nobody asked for.
- **A second control write while busy (R9).** A design that ignored the busy state would either pulse start twice or overwrite the frozen request payload.
- **Channel 5 with every condition met (R8).** A design that missed this channel's exclusion would start it.
- **Rewriting the address while busy (R6).** A design that drove the request outputs straight from the live registers would change the payload mid-transfer.

The random phase mixes enable patterns, start bits and channels against a bench model of the start rule.

// File: rtl/dma_bank_pkg.sv
package dma_bank_pkg;

  typedef enum logic [1:0] {
    FLD_ADDR = 2'd0,
    FLD_BLK  = 2'd1,
    FLD_CTL  = 2'd2,
    FLD_NONE = 2'd3
  } fld_e;

  localparam int CH_BASE   = 'h80;
  localparam int CH_STRIDE = 'h10;
  localparam int PRIM_OFS  = 'hF0;
  localparam int START_BIT = 24;

  function automatic int enable_pos(input int ch);
    return 3 + 4 * ch;
  endfunction

endpackage

// File: rtl/dma_bank_decode.sv
module dma_bank_decode
  import dma_bank_pkg::*;
#(
  parameter int NUM_CH = 7,
  parameter int AW     = 8
) (
  input  logic [AW-1:0]     addr,
  output logic [NUM_CH-1:0] ch_sel,
  output fld_e              fld,
  output logic              prim_hit
);

  always_comb begin
    case (addr[3:0])
      4'h0:    fld = FLD_ADDR;
      4'h4:    fld = FLD_BLK;
      4'h8:    fld = FLD_CTL;
      default: fld = FLD_NONE;
    endcase
  end

  assign prim_hit = (int'(addr) == PRIM_OFS);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
    assign ch_sel[i] = (int'(addr[AW-1:4]) == (CH_BASE / CH_STRIDE) + i) && (fld != FLD_NONE);
  end

endmodule

// File: rtl/dma_bank_chan.sv
module dma_bank_chan
  import dma_bank_pkg::*;
#(
  parameter int DW     = 32,
  parameter bit ACTIVE = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          sel,
  input  fld_e          fld,
  input  logic [DW-1:0] wdata,
  input  logic          enable,
  input  logic          done_in,
  output logic [DW-1:0] addr_q,
  output logic [DW-1:0] blk_q,
  output logic [DW-1:0] ctl_q,
  output logic          start_o,
  output logic          busy_o,
  output logic          fin_o,
  output logic [DW-1:0] req_addr,
  output logic [DW-1:0] req_blk,
  output logic [DW-1:0] req_ctl
);

  logic wr_addr, wr_blk, wr_ctl, launch, retire;

  assign wr_addr = wr && sel && (fld == FLD_ADDR);
  assign wr_blk  = wr && sel && (fld == FLD_BLK);
  assign wr_ctl  = wr && sel && (fld == FLD_CTL);
  assign launch  = ACTIVE && wr_ctl && wdata[START_BIT] && enable && !busy_o;
  assign retire  = done_in && busy_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q   <= '0;
      blk_q    <= '0;
      ctl_q    <= '0;
      start_o  <= 1'b0;
      busy_o   <= 1'b0;
      fin_o    <= 1'b0;
      req_addr <= '0;
      req_blk  <= '0;
      req_ctl  <= '0;
    end else begin
      if (wr_addr) addr_q <= wdata;
      if (wr_blk)  blk_q  <= wdata;
      if (wr_ctl)      ctl_q            <= wdata;
      else if (retire) ctl_q[START_BIT] <= 1'b0;
      start_o <= launch;
      fin_o   <= retire;
      if (launch)      busy_o <= 1'b1;
      else if (retire) busy_o <= 1'b0;
      if (launch) begin
        req_addr <= addr_q;
        req_blk  <= blk_q;
        req_ctl  <= wdata;
      end
    end
  end

endmodule

// File: rtl/dma_reg_bank.sv
module dma_reg_bank
  import dma_bank_pkg::*;
#(
  parameter int                NUM_CH    = 7,
  parameter int                AW        = 8,
  parameter int                DW        = 32,
  parameter logic [NUM_CH-1:0] IDLE_MASK = 7'b0100000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [AW-1:0]        reg_addr,
  input  logic [DW-1:0]        reg_wdata,
  output logic [DW-1:0]        reg_rdata,
  input  logic [NUM_CH-1:0]    xfer_done,
  output logic [NUM_CH-1:0]    xfer_start,
  output logic [NUM_CH-1:0]    xfer_busy,
  output logic [NUM_CH-1:0]    xfer_finish,
  output logic [NUM_CH*DW-1:0] xfer_addr,
  output logic [NUM_CH*DW-1:0] xfer_blk,
  output logic [NUM_CH*DW-1:0] xfer_ctl
);

  logic [NUM_CH-1:0] ch_sel;
  fld_e              fld;
  logic              prim_hit;
  logic [DW-1:0]     prim_q;
  logic [DW-1:0]     addr_q [NUM_CH];
  logic [DW-1:0]     blk_q  [NUM_CH];
  logic [DW-1:0]     ctl_q  [NUM_CH];
  logic [DW-1:0]     rd_mux;

  dma_bank_decode #(.NUM_CH(NUM_CH), .AW(AW)) u_dec (
    .addr     (reg_addr),
    .ch_sel   (ch_sel),
    .fld      (fld),
    .prim_hit (prim_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                  prim_q <= '0;
    else if (reg_wr && prim_hit) prim_q <= reg_wdata;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    dma_bank_chan #(.DW(DW), .ACTIVE(!IDLE_MASK[i])) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (reg_wr),
      .sel      (ch_sel[i]),
      .fld      (fld),
      .wdata    (reg_wdata),
      .enable   (prim_q[enable_pos(i)]),
      .done_in  (xfer_done[i]),
      .addr_q   (addr_q[i]),
      .blk_q    (blk_q[i]),
      .ctl_q    (ctl_q[i]),
      .start_o  (xfer_start[i]),
      .busy_o   (xfer_busy[i]),
      .fin_o    (xfer_finish[i]),
      .req_addr (xfer_addr[i*DW +: DW]),
      .req_blk  (xfer_blk[i*DW +: DW]),
      .req_ctl  (xfer_ctl[i*DW +: DW])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (prim_hit) rd_mux = prim_q;
    for (int i = 0; i < NUM_CH; i++) begin
      if (ch_sel[i]) begin
        case (fld)
          FLD_ADDR: rd_mux = addr_q[i];
          FLD_BLK:  rd_mux = blk_q[i];
          FLD_CTL:  rd_mux = ctl_q[i];
          default:  rd_mux = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

endmodule

// File: rtl/dma_reg_bank_chk.sv
module dma_reg_bank_chk
  import dma_bank_pkg::*;
#(
  parameter int NUM_CH = 7,
  parameter int AW     = 8,
  parameter int DW     = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_wr,
  input logic [AW-1:0]        reg_addr,
  input logic [DW-1:0]        reg_wdata,
  input logic [NUM_CH-1:0]    xfer_start,
  input logic [NUM_CH-1:0]    xfer_busy,
  input logic [NUM_CH-1:0]    xfer_finish,
  input logic [NUM_CH*DW-1:0] xfer_addr,
  input logic [NUM_CH*DW-1:0] xfer_blk,
  input logic [NUM_CH*DW-1:0] xfer_ctl
);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_p
    localparam logic [AW-1:0] CTL_OFS = AW'(CH_BASE + CH_STRIDE * i + 8);

    p_start_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start[i] |=> !xfer_start[i]);

    p_start_from_ctl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start[i] |-> ($past(reg_wr) && $past(reg_addr) == CTL_OFS &&
                         $past(reg_wdata[START_BIT]) &&
                         xfer_ctl[i*DW +: DW] == $past(reg_wdata)));

    p_req_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_busy[i] && !xfer_start[i]) |->
        ($stable(xfer_addr[i*DW +: DW]) && $stable(xfer_blk[i*DW +: DW]) &&
         $stable(xfer_ctl[i*DW +: DW])));

    p_finish_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_finish[i] |-> (!xfer_busy[i] && $past(xfer_busy[i])));

    p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start[i] |-> !$past(xfer_busy[i]));
  end

endmodule

bind dma_reg_bank dma_reg_bank_chk #(.NUM_CH(NUM_CH), .AW(AW), .DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr      (reg_wr),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .xfer_start  (xfer_start),
  .xfer_busy   (xfer_busy),
  .xfer_finish (xfer_finish),
  .xfer_addr   (xfer_addr),
  .xfer_blk    (xfer_blk),
  .xfer_ctl    (xfer_ctl)
);

// File: tb/dma_reg_bank_tb.sv
module dma_reg_bank_tb;

  localparam int NCH = 7;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             reg_wr = 1'b0;
  logic             reg_rd = 1'b0;
  logic [7:0]       reg_addr = '0;
  logic [31:0]      reg_wdata = '0;
  logic [31:0]      reg_rdata;
  logic [NCH-1:0]   xfer_done = '0;
  logic [NCH-1:0]   xfer_start, xfer_busy, xfer_finish;
  logic [NCH*32-1:0] xfer_addr, xfer_blk, xfer_ctl;

  int nchk = 0;
  int nfail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dma_reg_bank u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .xfer_done(xfer_done), .xfer_start(xfer_start), .xfer_busy(xfer_busy),
    .xfer_finish(xfer_finish), .xfer_addr(xfer_addr), .xfer_blk(xfer_blk),
    .xfer_ctl(xfer_ctl)
  );

  function automatic logic [7:0] ofs(input int ch, input int fld);
    return 8'(8'h80 + 16 * ch + 4 * fld);
  endfunction

  function automatic bit exp_start(input int ch, input logic [31:0] c,
                                   input logic [31:0] prim, input bit busy);
    return (ch != 5) && c[24] && prim[3 + 4 * ch] && !busy;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic pulse_done(input int ch);
    @(negedge clk); xfer_done = NCH'(1) << ch;
    @(negedge clk); xfer_done = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, a, b, c, prim;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 start", 32'(xfer_start), 0);
    chk("R1 busy", 32'(xfer_busy), 0);
    chk("R1 rdata", reg_rdata, 0);
    rd(ofs(3, 2), d); chk("R1 ctl", d, 0);
    rd(8'hF0, d); chk("R1 prim", d, 0);

    // R10 primary and unmapped, R11 read latency
    wr(8'hF0, 32'hFFFF_FFFF);
    rd(8'hF0, d); chk("R10 R11 prim readback", d, 32'hFFFF_FFFF);
    wr(ofs(0, 0), 32'h1234_5678);
    rd(ofs(0, 3), d); chk("R10 unmapped 0x8C", d, 0);
    rd(8'h00, d); chk("R10 unmapped 0x00", d, 0);
    rd(8'hFC, d); chk("R10 unmapped 0xFC", d, 0);

    // R8 channel 5 never starts
    wr(ofs(5, 2), 32'h0100_0005);
    chk("R8 no start", 32'(xfer_start), 0);
    chk("R8 no busy", 32'(xfer_busy), 0);
    rd(ofs(5, 2), d); chk("R8 stored", d, 32'h0100_0005);

    // R4 enable set later does not start
    wr(8'hF0, 32'h0);
    wr(ofs(2, 2), 32'h0100_0002);
    chk("R4 disabled no start", 32'(xfer_start), 0);
    wr(8'hF0, 32'hFFFF_FFFF);
    chk("R4 late enable no start", 32'(xfer_start), 0);
    @(negedge clk); chk("R4 late enable still idle", 32'(xfer_busy), 0);

    // R9 control write while busy
    wr(ofs(1, 0), 32'hAAAA_0001);
    wr(ofs(1, 2), 32'h0100_0011);
    chk("R3 start ch1", 32'(xfer_start), 32'h2);
    wr(ofs(1, 2), 32'h0100_0022);
    chk("R9 no restart", 32'(xfer_start), 0);
    chk("R9 payload kept", xfer_ctl[32 +: 32], 32'h0100_0011);
    rd(ofs(1, 2), d); chk("R9 stored", d, 32'h0100_0022);
    pulse_done(1);
    chk("R7 finish ch1", 32'(xfer_finish), 32'h2);

    // random mix: R2 R3 R5 R6 R7
    for (int it = 0; it < 80; it++) begin
      int ch;
      bit e;
      ch = int'($urandom % NCH);
      a = $urandom; b = $urandom; prim = $urandom;
      c = $urandom;
      c[24] = ($urandom % 4) != 0;
      wr(8'hF0, prim);
      wr(ofs(ch, 0), a);
      chk("R2 addr write no start", 32'(xfer_start), 0);
      wr(ofs(ch, 1), b);
      rd(ofs(ch, 0), d); chk("R2 addr readback", d, a);
      rd(ofs(ch, 1), d); chk("R2 blk readback", d, b);
      wr(ofs(ch, 2), c);
      e = exp_start(ch, c, prim, 1'b0);
      chk(c[24] ? "R3 R4 R8 start decision" : "R5 no start bit",
          32'(xfer_start), e ? (32'h1 << ch) : 0);
      if (e) begin
        chk("R3 req addr", xfer_addr[ch*32 +: 32], a);
        chk("R3 req blk", xfer_blk[ch*32 +: 32], b);
        chk("R3 req ctl", xfer_ctl[ch*32 +: 32], c);
        @(negedge clk); chk("R3 one cycle", 32'(xfer_start), 0);
        wr(ofs(ch, 0), ~a);
        chk("R6 addr frozen", xfer_addr[ch*32 +: 32], a);
        chk("R6 busy held", 32'(xfer_busy), 32'h1 << ch);
        pulse_done(ch);
        chk("R7 finish pulse", 32'(xfer_finish), 32'h1 << ch);
        chk("R7 busy cleared", 32'(xfer_busy), 0);
        @(negedge clk); chk("R7 finish one cycle", 32'(xfer_finish), 0);
        rd(ofs(ch, 2), d); chk("R7 start bit cleared", d, c & ~32'h0100_0000);
      end else begin
        rd(ofs(ch, 2), d); chk("R4 R5 ctl stored", d, c);
      end
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule